// File: doc/BRIEF.md
# PLL Power-Up Initialization Sequencer

This block takes a PLL from power-up to locked operation in hardware, with no software delay loops. It runs from the reference clock. Every microsecond wait is turned into a count of reference cycles, based on a reference-frequency parameter, and each count is rounded up.

After reset the block waits out the power-up settling time. It then accepts a start request together with a multiplier and a pre-divider. The sequence is fixed:

- If the PLL was left in bypass, the block first runs a power-down cycle.
- It moves the output into bypass and holds it there.
- It presents the new settings and a bandwidth-adjust value derived from the multiplier.
- It pulses the PLL reset.
- It waits for lock, for a time that scales with the pre-divider.
- It leaves bypass: it clears bypass first and then enables the PLL path.

A done flag tells the rest of the chip that the PLL clock is in use.

The power-down and reset controls, the bypass and enable controls, the saturation enable and the settings buses all connect straight to the PLL macro and its output switch. The analog loop and lock detection are outside this block.

Top module: `pll_boot_seq`

## Requirements
- R1: After reset is released the block stays busy for exactly ceil(100 µs × f_ref) reference cycles. A start request in that window is ignored.
- R2: The bandwidth-adjust value is ((M + 1) >> 1) − 1 taken to 12 bits, where M is the multiplier. `bw_lo` carries bits 7:0 and `bw_hi` carries bits 11:8. For M = 0 the value wraps to 0xFFF.
- R3: If bypass is already high when a start request is accepted, `sat_en` goes high and `pll_en` goes low in the cycle after acceptance. Four cycles later `pll_pwrdn` rises with bypass high. It stays high for exactly ceil(5 µs × f_ref) cycles and is then released.
- R4: `mult_out`, `div_out` and the bandwidth buses change only after `pll_en` has been low with bypass high for at least 4 consecutive cycles. The change happens in the same cycle that `pll_rst` rises.
- R5: `pll_rst` is high for exactly ceil(7 µs × f_ref) cycles.
- R6: Bypass falls exactly LOCK_PER_DIV × (D + 1) cycles after `pll_rst` falls, where D is the pre-divider.
- R7: Bypass is cleared one cycle before `pll_en` is set, and `pll_en` never rises while bypass is high.
- R8: `done` rises one cycle after `pll_en`. It stays high until the next accepted start request, which clears it in the following cycle, or until reset.
- R9: A start request while a sequence is running is ignored. Settings and timing follow the request that was accepted.
- R10: A start request with a multiplier of 4096 or more (bit 12 set) is ignored, and `busy`, `done` and the settings outputs keep their values.
- R11: During reset `pll_bypass` takes the value of `bypass_strap`. All other outputs are low, except `busy`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_strap | input | 1 | Bypass state the PLL was left in, loaded during reset |
| start | input | 1 | Start request, sampled in idle |
| mult_in | input | 13 | Requested multiplier |
| div_in | input | 6 | Requested pre-divider |
| pll_en | output | 1 | Selects the PLL path at the output switch |
| pll_bypass | output | 1 | Forces the output to the reference clock |
| pll_pwrdn | output | 1 | PLL power-down |
| pll_rst | output | 1 | PLL reset |
| sat_en | output | 1 | Saturation enable for the loop |
| mult_out | output | 13 | Multiplier applied to the PLL |
| div_out | output | 6 | Pre-divider applied to the PLL |
| bw_lo | output | 8 | Bandwidth adjust, low byte |
| bw_hi | output | 4 | Bandwidth adjust, high nibble |
| busy | output | 1 | Power-up wait or sequence in progress |
| done | output | 1 | PLL mode reached |

## Verification
Every register output moves exactly one reference cycle after the edge that changes the state. The bench drives inputs on falling edges and samples every output on falling edges. For each run it logs, against a cycle index, the negedge at which each control first rises or falls, counting from the start pulse. The bench then compares the following gaps with the numbers the requirements give:

- `sat_en` to `pll_pwrdn` rising: 4
- the power-down pulse: 8 at the bench's 1.5 MHz setting
- the reset pulse: 11
- reset release to bypass clear: 3 × (D + 1)
- bypass clear to `pll_en`: 1
- `pll_en` to `done`: 1

The power-up wait is counted in negedges from the one at which reset is released, giving 150. Ignored requests are judged at the outputs a fixed number of cycles later.

// File: rtl/pll_boot_seq.sv
module pll_boot_seq #(
  parameter int REF_KHZ      = 25000,
  parameter int LOCK_PER_DIV = 500,
  parameter int MULT_W       = 13,
  parameter int DIV_W        = 6,
  parameter int SWITCH_CYC   = 4
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              bypass_strap,
  input  logic              start,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [DIV_W-1:0]  div_in,
  output logic              pll_en,
  output logic              pll_bypass,
  output logic              pll_pwrdn,
  output logic              pll_rst,
  output logic              sat_en,
  output logic [MULT_W-1:0] mult_out,
  output logic [DIV_W-1:0]  div_out,
  output logic [7:0]        bw_lo,
  output logic [MULT_W-10:0] bw_hi,
  output logic              busy,
  output logic              done
);
  localparam int BW_W      = MULT_W - 1;
  localparam int PWRUP_CYC = (100 * REF_KHZ + 999) / 1000;
  localparam int PD_CYC    = (5 * REF_KHZ + 999) / 1000;
  localparam int RST_CYC   = (7 * REF_KHZ + 999) / 1000;
  localparam int LOCK_MAX  = LOCK_PER_DIV * (1 << DIV_W);
  localparam int MAX_A     = (PWRUP_CYC > LOCK_MAX) ? PWRUP_CYC : LOCK_MAX;
  localparam int MAX_B     = (PD_CYC > RST_CYC) ? PD_CYC : RST_CYC;
  localparam int MAX_C     = (MAX_B > SWITCH_CYC) ? MAX_B : SWITCH_CYC;
  localparam int CNT_MAX   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  typedef enum logic [3:0] {
    S_PWRUP, S_IDLE, S_SAT, S_PD, S_ENB, S_RST, S_LOCK, S_EXIT, S_ENA
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;
  logic [MULT_W-1:0] m_inc;
  logic [BW_W-1:0]   bw;
  logic [CNT_W-1:0]  lock_last;
  logic              cnt_zero;
  logic              accept;

  assign cnt_zero  = (cnt == '0);
  assign accept    = (state == S_IDLE) && start && !mult_in[MULT_W-1];
  assign m_inc     = mult_q + MULT_W'(1);
  assign bw        = m_inc[MULT_W-1:1] - BW_W'(1);
  assign lock_last = CNT_W'(LOCK_PER_DIV * (int'(div_q) + 1) - 1);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      state      <= S_PWRUP;
      cnt        <= CNT_W'(PWRUP_CYC - 1);
      pll_en     <= 1'b0;
      pll_bypass <= bypass_strap;
      pll_pwrdn  <= 1'b0;
      pll_rst    <= 1'b0;
      sat_en     <= 1'b0;
      done       <= 1'b0;
      mult_q     <= '0;
      div_q      <= '0;
      mult_out   <= '0;
      div_out    <= '0;
      bw_lo      <= '0;
      bw_hi      <= '0;
    end else begin
      if (!cnt_zero) cnt <= cnt - CNT_W'(1);
      case (state)
        S_PWRUP: if (cnt_zero) state <= S_IDLE;
        S_IDLE: if (accept) begin
          done   <= 1'b0;
          mult_q <= mult_in;
          div_q  <= div_in;
          pll_en <= 1'b0;
          cnt    <= CNT_W'(SWITCH_CYC - 1);
          if (pll_bypass) begin
            sat_en <= 1'b1;
            state  <= S_SAT;
          end else begin
            pll_bypass <= 1'b1;
            state      <= S_ENB;
          end
        end
        S_SAT: if (cnt_zero) begin
          pll_bypass <= 1'b1;
          pll_pwrdn  <= 1'b1;
          cnt        <= CNT_W'(PD_CYC - 1);
          state      <= S_PD;
        end
        S_PD: if (cnt_zero) begin
          pll_pwrdn <= 1'b0;
          pll_en    <= 1'b0;
          cnt       <= CNT_W'(SWITCH_CYC - 1);
          state     <= S_ENB;
        end
        S_ENB: if (cnt_zero) begin
          mult_out <= mult_q;
          div_out  <= div_q;
          bw_lo    <= bw[7:0];
          bw_hi    <= bw[BW_W-1:8];
          pll_rst  <= 1'b1;
          cnt      <= CNT_W'(RST_CYC - 1);
          state    <= S_RST;
        end
        S_RST: if (cnt_zero) begin
          pll_rst <= 1'b0;
          cnt     <= lock_last;
          state   <= S_LOCK;
        end
        S_LOCK: if (cnt_zero) begin
          pll_bypass <= 1'b0;
          state      <= S_EXIT;
        end
        S_EXIT: begin
          pll_en <= 1'b1;
          state  <= S_ENA;
        end
        S_ENA: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_NEEDS_EN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    done |-> (pll_en && !pll_bypass)); // R8
  AST_EN_AFTER_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pll_en) |-> !pll_bypass); // R7
  AST_BYPASS_BEFORE_EN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(pll_bypass) |-> !pll_en); // R7
  AST_CFG_IN_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(mult_out) |-> (!pll_en && pll_bypass && pll_rst)); // R4
  AST_PWRDN_IN_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_pwrdn |-> (pll_bypass && !pll_en && !pll_rst)); // R3
  AST_RST_IN_BYPASS: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pll_rst |-> (pll_bypass && !pll_en && !pll_pwrdn)); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(div_out)) |-> pll_rst); // R9
endmodule

// File: tb/pll_boot_seq_tb.sv
module pll_boot_seq_tb;
  localparam int REF_KHZ = 1500;
  localparam int LPD     = 3;
  localparam int PW      = 150;
  localparam int PD      = 8;
  localparam int RS      = 11;

  logic        clk_ref = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass_strap = 1'b0;
  logic        start = 1'b0;
  logic [12:0] mult_in = '0;
  logic [5:0]  div_in = '0;
  logic        pll_en, pll_bypass, pll_pwrdn, pll_rst, sat_en, busy, done;
  logic [12:0] mult_out;
  logic [5:0]  div_out;
  logic [7:0]  bw_lo;
  logic [3:0]  bw_hi;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk_ref = ~clk_ref;

  pll_boot_seq #(.REF_KHZ(REF_KHZ), .LOCK_PER_DIV(LPD)) u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .bypass_strap(bypass_strap), .start(start),
    .mult_in(mult_in), .div_in(div_in), .pll_en(pll_en), .pll_bypass(pll_bypass),
    .pll_pwrdn(pll_pwrdn), .pll_rst(pll_rst), .sat_en(sat_en), .mult_out(mult_out),
    .div_out(div_out), .bw_lo(bw_lo), .bw_hi(bw_hi), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    int n;
    rst_n = 1'b0;
    bypass_strap = strap;
    repeat (4) @(negedge clk_ref);
    chk(pll_bypass == strap && !pll_en && !pll_pwrdn && !pll_rst && !sat_en &&
        !done && busy && mult_out == 0, "R11 reset state", int'(pll_bypass), int'(strap));
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 10000) begin
      n++;
      start = (n == 20);
      mult_in = 13'd5;
      @(negedge clk_ref);
    end
    start = 1'b0;
    chk(n == PW, "R1 power-up wait", n, PW);
    repeat (10) @(negedge clk_ref);
    chk(!busy && !done && !pll_rst && mult_out == 0, "R1 start in power-up ignored",
        int'(busy), 0);
  endtask

  task automatic run_seq(input logic [12:0] m, input logic [5:0] d, input bit via_pd,
                         input bit inject);
    int t, t_sat, t_pdr, t_pdf, t_rr, t_rf, t_bf, t_er, t_dn, lowrun, low_at_rr;
    bit bad_cfg;
    logic p_sat, p_pd, p_rst, p_byp, p_en, p_done;
    logic [12:0] p_mult;
    int exp_bw;
    exp_bw = (((int'(m) + 1) >> 1) - 1) & 'hFFF;
    t_sat = -1; t_pdr = -1; t_pdf = -1; t_rr = -1; t_rf = -1; t_bf = -1;
    t_er = -1; t_dn = -1; lowrun = 0; low_at_rr = 0; bad_cfg = 1'b0;
    p_sat = sat_en; p_pd = pll_pwrdn; p_rst = pll_rst; p_byp = pll_bypass;
    p_en = pll_en; p_done = done; p_mult = mult_out;
    mult_in = m; div_in = d; start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    chk(!done, "R8 done cleared by start", int'(done), 0);
    t = 0;
    while (t < 20000) begin
      if (inject) begin
        start = (t == 6);
        mult_in = 13'd77;
        div_in = 6'd9;
      end
      if (sat_en && !p_sat) t_sat = t;
      if (pll_pwrdn && !p_pd) t_pdr = t;
      if (!pll_pwrdn && p_pd) t_pdf = t;
      if (pll_rst && !p_rst) begin t_rr = t; low_at_rr = lowrun; end
      if (!pll_rst && p_rst) t_rf = t;
      if (!pll_bypass && p_byp) t_bf = t;
      if (pll_en && !p_en) t_er = t;
      if (mult_out != p_mult && !(pll_rst && !p_rst)) bad_cfg = 1'b1;
      lowrun = (!pll_en && pll_bypass && !pll_rst) ? lowrun + 1 : 0;
      p_sat = sat_en; p_pd = pll_pwrdn; p_rst = pll_rst; p_byp = pll_bypass;
      p_en = pll_en; p_mult = mult_out;
      if (done) begin t_dn = t; break; end
      @(negedge clk_ref);
      t++;
    end
    start = 1'b0;
    chk(t_dn >= 0, "R8 done reached", t_dn, 0);
    if (via_pd) begin
      chk(t_sat == 0, "R3 sat_en after accept", t_sat, 0);
      chk(t_pdr == 4, "R3 power-down start", t_pdr, 4);
      chk(t_pdf - t_pdr == PD, "R3 power-down length", t_pdf - t_pdr, PD);
    end else begin
      chk(t_pdr == -1 && !sat_en, "R3 no power-down without bypass", t_pdr, -1);
    end
    chk(low_at_rr >= 4, "R4 bypass hold before settings", low_at_rr, 4);
    chk(!bad_cfg, "R4 settings change only at reset rise", int'(bad_cfg), 0);
    chk(t_rf - t_rr == RS, "R5 reset length", t_rf - t_rr, RS);
    chk(t_bf - t_rf == LPD * (int'(d) + 1), "R6 lock wait", t_bf - t_rf, LPD * (int'(d) + 1));
    chk(t_er - t_bf == 1, "R7 enable after bypass clear", t_er - t_bf, 1);
    chk(t_dn - t_er == 1, "R8 done after enable", t_dn - t_er, 1);
    chk(mult_out == m && div_out == d, "R9 settings of accepted request",
        int'(mult_out), int'(m));
    chk({bw_hi, bw_lo} == 12'(exp_bw), "R2 bandwidth adjust", int'({bw_hi, bw_lo}), exp_bw);
    repeat (20) @(negedge clk_ref);
    chk(done && pll_en && !busy, "R8 done holds", int'(done), 1);
  endtask

  task automatic bad_mult;
    logic [12:0] keep;
    keep = mult_out;
    mult_in = 13'd4096; div_in = 6'd2; start = 1'b1;
    @(negedge clk_ref);
    start = 1'b0;
    repeat (10) @(negedge clk_ref);
    chk(!busy && done && mult_out == keep && pll_en, "R10 oversize multiplier ignored",
        int'(busy), 0);
  endtask

  initial begin
    do_reset(1'b0);
    run_seq(13'd19, 6'd0, 1'b0, 1'b0);
    run_seq(13'd4095, 6'd5, 1'b0, 1'b0);
    run_seq(13'd0, 6'd63, 1'b0, 1'b1);
    bad_mult();
    do_reset(1'b1);
    run_seq(13'd100, 6'd2, 1'b1, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule